// File: doc/BRIEF.md
# Feedback Divider with Phase Build-Out

This block divides an oscillator-rate clock by a selectable power of two, from 1 to 512. The divided clock is the feedback input of a PLL phase detector, applied to its non-inverting side. A 4-bit select code picks the ratio through a fixed decode. One code is reserved for test and parks the output instead of dividing.

A change of the reference multiplexer, whether made by hand or by automatic failover, is reported to the block as a single-cycle reselect pulse. When build-out is enabled, that pulse arms a one-shot rephasing. The next reference edge indicator, which arrives already synchronised into the oscillator domain, comes with a sub-cycle fraction that says where the edge fell. The block reloads its count so that the feedback grid lands on whichever oscillator edge is nearer that reference edge. The PLL then absorbs the phase step between the old and new references instead of slewing through it. With build-out disabled, the divider counts through reselections untouched.

Top module: `fbdiv_buildout`

## Requirements
- R1: The select code sets the ratio M as follows.
  - Codes 0000, 0001, 0010 and 0011 give 8, 32, 128 and 512. When parameter LOW_ROW_ALT is 1, the same codes give 4, 16, 64 and 256.
  - Codes 0100 to 0111 give 2, 8, 32 and 128.
  - Codes 1000 to 1011 give 1, 4, 16 and 64.
  - Codes 1101 to 1111 give 1, 4 and 16.
- R2: For M of 2 or more, the output is periodic with period M oscillator cycles. It is high for the first M/2 cycles of each period, and its rising edge is the feedback edge.
- R3: For M equal to 1, the output follows the oscillator clock itself (high while the clock is high, low while it is low).
- R4: Code 1100 is a test setting that holds the output low with the divider idle. When a dividing code replaces it, the code loads at the next clock edge, and the first rising edge follows one edge later.
- R5: A change of select code is applied only at the end of the running period. The period in progress completes at the old length, so no runt pulse is produced.
- R6: When build-out is enabled, a reselect pulse arms one rephasing, which fires on the first reference edge indicator seen on a later cycle. Let the indicator be sampled at edge t. ref_frac_i is the position of the reference edge after edge t-1, in units of 1/2^FRAC_W of a period.
  - A fraction below one half aligns the grid to edge t-1, so the next rising edge comes M-1 cycles after t.
  - A fraction above one half aligns it to edge t, so the next rising edge comes M cycles after t.
- R7: A fraction of exactly one half (a tie) rounds toward the earlier edge t-1.
- R8: A reference edge indicator has no effect unless a rephasing is armed. Only the first indicator after an arming is used.
- R9: With build-out disabled, reselect pulses are ignored and the divider counts freely. Dropping the enable also cancels a rephasing that is armed.
- R10: Reset drives the output low, clears the counter and drops any armed rephasing. After reset is released, the select code loads at the first clock edge and the first rising edge follows at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msel_i | input | 4 | Divide ratio select code |
| pbo_en_i | input | 1 | Build-out enable |
| resel_i | input | 1 | One-cycle pulse on a reference multiplexer change |
| ref_edge_i | input | 1 | Synchronised indicator of a new reference edge |
| ref_frac_i | input | FRAC_W | Sub-cycle position of that reference edge |
| fb_clk_o | output | 1 | Feedback clock to the phase detector |

## Verification
The assertions assume the following about the inputs:
- the reference edge indicator and the reselect signal are single-cycle pulses, synchronous to the oscillator clock;
- the fraction is valid in the same cycle as the indicator;
- the select code is held steady from one clock edge to the next.

The stimulus changes every input one nanosecond after a rising edge and holds it through the next edge. It issues the reselect pulse at least one cycle ahead of the reference edge, and it samples the output only between edges.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned LG_W   = 4;
  localparam int unsigned MAX_LG = 9;
  localparam int unsigned CNT_W  = MAX_LG;

  typedef struct packed {
    logic            test;
    logic [LG_W-1:0] lg;
  } div_cfg_t;

  localparam div_cfg_t CFG_RESET = '{test: 1'b1, lg: '0};

  // select code -> log2 of divide ratio
  function automatic div_cfg_t decode_sel(input logic [SEL_W-1:0] code,
                                          input logic [LG_W-1:0]  row0_base);
    div_cfg_t c;
    logic [LG_W-1:0] twice_k;
    twice_k = LG_W'({code[1:0], 1'b0});
    c.test  = 1'b0;
    c.lg    = '0;
    case (code[3:2])
      2'b00:   c.lg = row0_base + twice_k;
      2'b01:   c.lg = twice_k + LG_W'(1);
      2'b10:   c.lg = twice_k;
      default: begin
        c.test = (code[1:0] == 2'b00);
        c.lg   = c.test ? '0 : twice_k - LG_W'(2);
      end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
  import fbdiv_pkg::*;
#(
  parameter bit LOW_ROW_ALT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tc_i,
  output div_cfg_t         cfg_q_o,
  output div_cfg_t         cfg_d_o
);
  logic [LG_W-1:0] row0_base;
  div_cfg_t        cfg_q;

  generate
    if (LOW_ROW_ALT) begin : g_row_alt
      assign row0_base = LG_W'(2);
    end else begin : g_row_std
      assign row0_base = LG_W'(3);
    end
  endgenerate

  // reload only at terminal count
  assign cfg_d_o = tc_i ? decode_sel(sel_i, row0_base) : cfg_q;
  assign cfg_q_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else         cfg_q <= cfg_d_o;
  end

  p_cfg_only_at_tc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_i |=> $stable(cfg_q));
endmodule

// File: rtl/fbdiv_pbo_ctrl.sv
module fbdiv_pbo_ctrl #(
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              resel_i,
  input  logic              ref_edge_i,
  input  logic [FRAC_W-1:0] ref_frac_i,
  output logic              load_o,
  output logic              early_o
);
  localparam logic [FRAC_W-1:0] FRAC_HALF = FRAC_W'(2 ** (FRAC_W - 1));

  logic pending_q, pending_d;

  assign load_o    = en_i & pending_q & ref_edge_i;
  // tie rounds to the earlier oscillator edge
  assign early_o   = (ref_frac_i <= FRAC_HALF);
  assign pending_d = en_i & (resel_i | (pending_q & ~ref_edge_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= pending_d;
  end

  p_cancel_on_disable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pending_q);

  p_one_shot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !resel_i) |=> !load_o);
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
  import fbdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  div_cfg_t cfg_q_i,
  input  div_cfg_t cfg_d_i,
  input  logic     load_i,
  input  logic     early_i,
  output logic     tc_o,
  output logic     fb_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, ld_val, top_nxt;
  logic [CNT_W:0]   m_cur, m_nxt, half_nxt;
  logic             fb_q, fb_d;

  assign m_cur    = (CNT_W + 1)'(1) << cfg_q_i.lg;
  assign m_nxt    = (CNT_W + 1)'(1) << cfg_d_i.lg;
  assign half_nxt = m_nxt >> 1;
  assign top_nxt  = CNT_W'(m_nxt - 1'b1);
  assign tc_o     = cfg_q_i.test | ({1'b0, cnt_q} == m_cur - 1'b1);

  // early: grid on previous edge, so this edge is already count 1
  assign ld_val = (cfg_d_i.test || !early_i || cfg_d_i.lg == '0) ? '0 : CNT_W'(1);

  always_comb begin
    if (cfg_q_i.test)  cnt_d = cfg_d_i.test ? '0 : top_nxt;
    else if (load_i)   cnt_d = ld_val;
    else if (tc_o)     cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
    fb_d = (cfg_q_i.test | cfg_d_i.test) ? 1'b0 : ({1'b0, cnt_d} < half_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fb_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fb_q  <= fb_d;
    end
  end

  assign fb_o = fb_q;

  p_rise_at_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fb_q) |-> (cnt_q == '0) || $past(load_i));

  p_load_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !cfg_q_i.test && !cfg_d_i.test) |=> (cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/fbdiv_buildout.sv
module fbdiv_buildout
  import fbdiv_pkg::*;
#(
  parameter bit          LOW_ROW_ALT = 1'b0,
  parameter int unsigned FRAC_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  msel_i,
  input  logic              pbo_en_i,
  input  logic              resel_i,
  input  logic              ref_edge_i,
  input  logic [FRAC_W-1:0] ref_frac_i,
  output logic              fb_clk_o
);
  div_cfg_t cfg_q, cfg_d;
  logic     tc, load, early, fb_q;

  fbdiv_cfg #(.LOW_ROW_ALT(LOW_ROW_ALT)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (msel_i),
    .tc_i    (tc),
    .cfg_q_o (cfg_q),
    .cfg_d_o (cfg_d)
  );

  fbdiv_pbo_ctrl #(.FRAC_W(FRAC_W)) u_pbo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pbo_en_i),
    .resel_i    (resel_i),
    .ref_edge_i (ref_edge_i),
    .ref_frac_i (ref_frac_i),
    .load_o     (load),
    .early_o    (early)
  );

  fbdiv_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_q_i (cfg_q),
    .cfg_d_i (cfg_d),
    .load_i  (load),
    .early_i (early),
    .tc_o    (tc),
    .fb_o    (fb_q)
  );

  // divide by one: clock passes straight through
  assign fb_clk_o = (!cfg_q.test && cfg_q.lg == '0) ? clk_i : fb_q;

  p_test_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.test |-> !fb_clk_o);
endmodule

// File: tb/fbdiv_buildout_tb.sv
`timescale 1ns/1ps
module fbdiv_buildout_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] msel = 4'b0000;
  logic       pbo_en = 1'b0, resel = 1'b0, ref_edge = 1'b0;
  logic [2:0] ref_frac = 3'd0;
  logic       fb_clk;
  logic       fb_prev = 1'b0, rise = 1'b0;
  int         n_chk = 0, n_bad = 0;

  // {code, expected M}
  localparam logic [15:0] VEC [13] = '{
    {4'b0000, 12'd8},  {4'b0001, 12'd32}, {4'b0010, 12'd128}, {4'b0011, 12'd512},
    {4'b0100, 12'd2},  {4'b0101, 12'd8},  {4'b0110, 12'd32},  {4'b0111, 12'd128},
    {4'b1001, 12'd4},  {4'b1010, 12'd16}, {4'b1011, 12'd64},  {4'b1110, 12'd4},
    {4'b1111, 12'd16}
  };

  always #2 clk = ~clk;

  fbdiv_buildout u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .msel_i     (msel),
    .pbo_en_i   (pbo_en),
    .resel_i    (resel),
    .ref_edge_i (ref_edge),
    .ref_frac_i (ref_frac),
    .fb_clk_o   (fb_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    rise    = fb_clk & ~fb_prev;
    fb_prev = fb_clk;
  endtask

  task automatic ticks_to_rise(output int n);
    n = 0;
    rise = 1'b0;
    while (!rise && n < 2000) begin
      tick();
      n++;
    end
  endtask

  task automatic measure(output int per, output int hi);
    per = 0;
    hi = 1;
    rise = 1'b0;
    while (!rise && per < 2000) begin
      tick();
      per++;
      if (!rise && fb_clk) hi++;
    end
  endtask

  // called at a rise sample; reselect, then reference edge 5 cycles in
  task automatic pbo_case(input logic [2:0] frac, input int exp, input string tag);
    int n;
    repeat (2) tick();
    resel = 1'b1;
    tick();
    resel = 1'b0;
    tick();
    ref_edge = 1'b1;
    ref_frac = frac;
    tick();
    ref_edge = 1'b0;
    ticks_to_rise(n);
    chk(tag, n, exp);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, per, hi;
    // R10 reset state and restart
    repeat (3) tick();
    chk("R10 output low in reset", fb_clk, 0);
    rst_ni = 1'b1;
    ticks_to_rise(n);
    chk("R10 first rise after release", n, 2);

    // R1 / R2 vector walk
    for (int i = 0; i < 13; i++) begin
      msel = VEC[i][15:12];
      ticks_to_rise(n);
      measure(per, hi);
      chk($sformatf("R1 period code %b", VEC[i][15:12]), per, int'(VEC[i][11:0]));
      chk($sformatf("R2 high time code %b", VEC[i][15:12]), hi, int'(VEC[i][11:0]) / 2);
    end

    // R5 change applied only at terminal count
    msel = 4'b0000;
    ticks_to_rise(n);
    measure(per, hi);
    msel = 4'b0100;
    measure(per, hi);
    chk("R5 running period kept", per, 8);
    chk("R5 running high time kept", hi, 4);
    measure(per, hi);
    chk("R5 new period", per, 2);

    // R3 divide by one
    foreach (VEC[k]) begin end
    msel = 4'b1000;
    repeat (4) tick();
    hi = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (fb_clk) hi++;
      @(negedge clk); #1;
      if (!fb_clk) hi++;
    end
    chk("R3 code 1000 follows clock", hi, 8);
    msel = 4'b1101;
    repeat (2) tick();
    hi = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (fb_clk) hi++;
      @(negedge clk); #1;
      if (!fb_clk) hi++;
    end
    chk("R3 code 1101 follows clock", hi, 8);

    // R4 test code
    msel = 4'b1100;
    repeat (3) tick();
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (fb_clk) hi++;
      @(negedge clk); #1;
      if (fb_clk) hi++;
    end
    chk("R4 test code holds low", hi, 0);
    fb_prev = fb_clk;
    msel = 4'b0100;
    ticks_to_rise(n);
    chk("R4 restart after test code", n, 2);

    // R6 / R7 build-out with M=16; free-running rise would be 11
    pbo_en = 1'b1;
    msel = 4'b1010;
    ticks_to_rise(n);
    measure(per, hi);
    pbo_case(3'd1, 15, "R6 early fraction");
    pbo_case(3'd6, 16, "R6 late fraction");
    pbo_case(3'd4, 15, "R7 tie rounds earlier");
    measure(per, hi);
    chk("R6 period after rephase", per, 16);

    // R8 edge without arming, then second edge after a rephase
    repeat (4) tick();
    ref_edge = 1'b1;
    ref_frac = 3'd6;
    tick();
    ref_edge = 1'b0;
    ticks_to_rise(n);
    chk("R8 unarmed edge ignored", n, 11);
    pbo_case(3'd6, 16, "R8 armed rephase");
    repeat (4) tick();
    ref_edge = 1'b1;
    ref_frac = 3'd1;
    tick();
    ref_edge = 1'b0;
    ticks_to_rise(n);
    chk("R8 second edge ignored", n, 11);

    // R9 disabled and cancelled
    pbo_en = 1'b0;
    pbo_case(3'd6, 11, "R9 disabled counts freely");
    pbo_en = 1'b1;
    repeat (2) tick();
    resel = 1'b1;
    tick();
    resel = 1'b0;
    pbo_en = 1'b0;
    tick();
    pbo_en = 1'b1;
    ref_edge = 1'b1;
    ref_frac = 3'd6;
    tick();
    ref_edge = 1'b0;
    ticks_to_rise(n);
    chk("R9 enable drop cancels", n, 11);

    // R10 reset drops armed rephase
    tick();
    resel = 1'b1;
    tick();
    resel = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R10 async reset output low", fb_clk, 0);
    tick();
    fb_prev = fb_clk;
    rst_ni = 1'b1;
    ticks_to_rise(n);
    chk("R10 rise after second release", n, 2);
    ref_edge = 1'b1;
    ref_frac = 3'd6;
    tick();
    ref_edge = 1'b0;
    ticks_to_rise(n);
    chk("R10 armed rephase cleared", n + 1, 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule